// File: doc/BRIEF.md
# Reset Sequencer with Cause Capture

This block gathers every reset request of a small microcontroller and turns it into one timed internal reset. Six sources feed it: an external active-low reset pin, a power-on pulse, a low-voltage pulse, a watchdog timeout, an illegal opcode and an illegal address. The analog detectors and the fault logic deliver single-cycle pulses.

A request from inside the chip makes the block pull the open-drain reset pin low for a fixed window, so that parts on the board are reset as well. After that window the internal reset stays on for a further window. Power-on and low-voltage requests first add a long stabilisation phase, with the pin held low throughout. A reset from the pin is accepted only after the pin has been low for long enough. The block records the cause in a status register, supplies the reset vector address and pulses a clear for a shared cycle counter. The counter is cleared for internal causes only.

Top module: `rst_sequencer`

## Requirements
- R1: After the synchronous reset `rst`, `sys_rst`, `rst_pin_drive` and `cnt_clr` are 0 and `cause_status` is 0.
- R2: A watchdog, illegal-opcode, illegal-address, low-voltage or power-on pulse makes `cnt_clr` high for exactly one cycle, starting in the cycle after the pulse. A qualified pin reset never raises `cnt_clr`.
- R3: The bits of `cause_status` are: bit 0 power-on, bit 1 low-voltage, bit 2 watchdog, bit 3 illegal opcode, bit 4 illegal address, bit 5 reset pin. A cause taken while `sys_rst` is low replaces the whole register with that cause. A cause other than power-on taken while `sys_rst` is high is ORed into the register.
- R4: The pin input passes through a two-flop synchroniser. The pin cause is taken only when the pin has been low for 67 consecutive clock cycles. A 66-cycle low has no effect on `sys_rst` or `cause_status`. The block's own 32-cycle pin drive never qualifies.
- R5: A power-on or low-voltage pulse holds `rst_pin_drive` and `sys_rst` high for a 4096-cycle stabilisation phase, starting in the cycle after the pulse. Pin qualification is suspended during this phase. With the pin held low from the power-on pulse onward, bit 5 is not yet set 4163 cycles later.
- R6: A watchdog, illegal-opcode or illegal-address pulse drives `rst_pin_drive` high for exactly 32 cycles, starting in the cycle after the pulse. After stabilisation, a power-on or low-voltage sequence does the same.
- R7: When the pin drive ends, `sys_rst` stays high for exactly 32 more cycles and then falls.
- R8: A power-on pulse sets `cause_status` to 6'b000001 even while a sequence is active, clearing every other bit.
- R9: A short-source pulse during the drive, hold or pin phase restarts the 32 + 32 sequence from its first cycle. A power-on or low-voltage pulse restarts stabilisation in any phase. A short-source pulse during stabilisation does not shorten it.
- R10: `reset_vec` is 16'hFFFE when `monitor_mode` is 0 and 16'hFEFE when it is 1. The low vector byte sits at the next address.
- R11: A qualified pin reset holds `sys_rst` high while the pin stays low, never drives the pin, and releases `sys_rst` 32 cycles after the synchronised pin reads high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the block's flops |
| rst_pin_n_in | input | 1 | Level read back from the open-drain reset pin (asynchronous) |
| por_evt | input | 1 | Power-on pulse |
| lvd_evt | input | 1 | Low-voltage pulse |
| wdog_evt | input | 1 | Watchdog timeout pulse |
| bad_op_evt | input | 1 | Illegal opcode pulse |
| bad_addr_evt | input | 1 | Illegal address pulse |
| monitor_mode | input | 1 | Selects the monitor reset vector |
| rst_pin_drive | output | 1 | 1 pulls the reset pin low |
| sys_rst | output | 1 | Internal reset to the rest of the chip |
| cnt_clr | output | 1 | One-cycle clear for the shared cycle counter |
| reset_vec | output | 16 | Address of the high byte of the reset vector |
| cause_status | output | 6 | Recorded reset cause |

## Verification
Each internal source is fired alone from idle, once with monitor mode on and once as a simultaneous pair. This separates the short 32 + 32 sequence from the long one with stabilisation, and shows that an idle-time cause replaces the previous status. Pin lows of 66 and 67 cycles show where the qualification threshold lies. A pin held low from power-on shows that qualification is suspended during stabilisation. Pulses that overlap an active sequence separate a restart of the sequence from an ignored pulse, and separate OR-ing of the status from the clearing that power-on does.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_STAB  = 3'd1,
        SQ_DRIVE = 3'd2,
        SQ_HOLD  = 3'd3,
        SQ_EXT   = 3'd4
    } seq_state_e;

    // Bit order matches the status register: pin is bit 5, power-on is bit 0.
    typedef struct packed {
        logic pin;
        logic bad_addr;
        logic bad_op;
        logic wdog;
        logic lvd;
        logic por;
    } cause_t;

    localparam int unsigned NUM_CAUSE = 6;
    localparam logic [15:0] VEC_NORMAL  = 16'hFFFE;
    localparam logic [15:0] VEC_MONITOR = 16'hFEFE;

    function automatic logic is_long_cause(input cause_t c);
        return c.por | c.lvd;
    endfunction

    function automatic logic is_short_cause(input cause_t c);
        return c.wdog | c.bad_op | c.bad_addr;
    endfunction

    function automatic logic [15:0] vector_for(input logic mon);
        return mon ? VEC_MONITOR : VEC_NORMAL;
    endfunction

endpackage

// File: rtl/rst_pin_qual.sv
module rst_pin_qual #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned PIN_QUAL    = 67
) (
    input  logic clk,
    input  logic rst,
    input  logic pin_n_async,
    input  logic inhibit,
    output logic pin_low,
    output logic qual
);
    localparam int unsigned QW = $clog2(PIN_QUAL + 1);

    logic [SYNC_STAGES-1:0] chain;
    logic [QW-1:0]          run_cnt;

    always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[SYNC_STAGES-2:0], pin_n_async};
    end

    assign pin_low = ~chain[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        qual <= 1'b0;
        if (rst || inhibit || !pin_low) begin
            run_cnt <= '0;
        end else if (run_cnt == QW'(PIN_QUAL - 1)) begin
            run_cnt <= QW'(PIN_QUAL);
            qual    <= 1'b1;
        end else if (run_cnt != QW'(PIN_QUAL)) begin
            run_cnt <= run_cnt + 1'b1;
        end
    end

    // R4
    inhibit_clear_chk: assert property (@(posedge clk) disable iff (rst)
        inhibit |=> (run_cnt == '0 && !qual));
    // R4
    qual_needs_low_chk: assert property (@(posedge clk) disable iff (rst)
        qual |-> $past(pin_low));

endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl
    import rstseq_pkg::*;
#(
    parameter int unsigned STAB_CYCLES  = 4096,
    parameter int unsigned DRIVE_CYCLES = 32,
    parameter int unsigned HOLD_CYCLES  = 32
) (
    input  logic   clk,
    input  logic   rst,
    input  cause_t evt,
    input  logic   pin_low,
    output logic   pin_drive,
    output logic   sys_rst,
    output logic   stab_phase,
    output logic   cnt_clr
);
    localparam int unsigned M1 = (STAB_CYCLES > DRIVE_CYCLES) ? STAB_CYCLES : DRIVE_CYCLES;
    localparam int unsigned MX = (M1 > HOLD_CYCLES) ? M1 : HOLD_CYCLES;
    localparam int unsigned CW = $clog2(MX + 1);

    seq_state_e    st, st_n;
    logic [CW-1:0] cnt, cnt_n;
    logic          long_req, short_req;

    assign long_req  = is_long_cause(evt);
    assign short_req = is_short_cause(evt);

    always_comb begin
        st_n  = st;
        cnt_n = cnt + 1'b1;
        unique case (st)
            SQ_IDLE: cnt_n = '0;
            SQ_STAB: if (cnt == CW'(STAB_CYCLES - 1)) begin
                st_n = SQ_DRIVE; cnt_n = '0;
            end
            SQ_DRIVE: if (cnt == CW'(DRIVE_CYCLES - 1)) begin
                st_n = SQ_HOLD; cnt_n = '0;
            end
            SQ_HOLD: if (cnt == CW'(HOLD_CYCLES - 1)) begin
                st_n = SQ_IDLE; cnt_n = '0;
            end
            SQ_EXT: begin
                cnt_n = '0;
                if (!pin_low) st_n = SQ_HOLD;
            end
            default: begin
                st_n = SQ_IDLE; cnt_n = '0;
            end
        endcase
        if (long_req) begin
            st_n = SQ_STAB; cnt_n = '0;
        end else if (short_req && st != SQ_STAB) begin
            st_n = SQ_DRIVE; cnt_n = '0;
        end else if (evt.pin && (st == SQ_IDLE || st == SQ_HOLD)) begin
            st_n = SQ_EXT; cnt_n = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= SQ_IDLE;
            cnt     <= '0;
            cnt_clr <= 1'b0;
        end else begin
            st      <= st_n;
            cnt     <= cnt_n;
            cnt_clr <= long_req | short_req;
        end
    end

    assign pin_drive  = (st == SQ_STAB) || (st == SQ_DRIVE);
    assign sys_rst    = (st != SQ_IDLE);
    assign stab_phase = (st == SQ_STAB);

    // R7
    hold_after_drive_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pin_drive) |-> sys_rst);
    // R7
    release_from_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(sys_rst) |-> $past(st == SQ_HOLD));
    // R5
    stab_then_drive_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(stab_phase) |-> (st == SQ_DRIVE));
    // R9
    restart_chk: assert property (@(posedge clk) disable iff (rst)
        (short_req && !long_req && st != SQ_STAB) |=> (st == SQ_DRIVE && cnt == '0));
    // R2
    clr_source_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_clr |-> $past(long_req || short_req));

endmodule

// File: rtl/rst_cause_log.sv
module rst_cause_log
    import rstseq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  cause_t evt,
    input  logic   active,
    output cause_t status
);
    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else if (evt != '0) begin
            if (evt.por || !active) status <= evt;
            else                    status <= status | evt;
        end
    end

    // R8
    por_clears_chk: assert property (@(posedge clk) disable iff (rst)
        evt.por |=> (status == $past(evt)));
    // R3
    sticky_while_active_chk: assert property (@(posedge clk) disable iff (rst)
        (active && !evt.por) |=> ((status & $past(status)) == $past(status)));

endmodule

// File: rtl/rst_sequencer.sv
module rst_sequencer
    import rstseq_pkg::*;
#(
    parameter int unsigned STAB_CYCLES  = 4096,
    parameter int unsigned DRIVE_CYCLES = 32,
    parameter int unsigned HOLD_CYCLES  = 32,
    parameter int unsigned PIN_QUAL     = 67,
    parameter int unsigned SYNC_STAGES  = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        rst_pin_n_in,
    input  logic        por_evt,
    input  logic        lvd_evt,
    input  logic        wdog_evt,
    input  logic        bad_op_evt,
    input  logic        bad_addr_evt,
    input  logic        monitor_mode,
    output logic        rst_pin_drive,
    output logic        sys_rst,
    output logic        cnt_clr,
    output logic [15:0] reset_vec,
    output logic [5:0]  cause_status
);
    logic   pin_low, pin_qual, stab_phase;
    cause_t evt_all, status;

    assign evt_all = '{pin: pin_qual, bad_addr: bad_addr_evt, bad_op: bad_op_evt,
                       wdog: wdog_evt, lvd: lvd_evt, por: por_evt};

    rst_pin_qual #(.SYNC_STAGES(SYNC_STAGES), .PIN_QUAL(PIN_QUAL)) u_qual (
        .clk(clk), .rst(rst), .pin_n_async(rst_pin_n_in), .inhibit(stab_phase),
        .pin_low(pin_low), .qual(pin_qual));

    rst_seq_ctrl #(.STAB_CYCLES(STAB_CYCLES), .DRIVE_CYCLES(DRIVE_CYCLES),
                   .HOLD_CYCLES(HOLD_CYCLES)) u_ctrl (
        .clk(clk), .rst(rst), .evt(evt_all), .pin_low(pin_low),
        .pin_drive(rst_pin_drive), .sys_rst(sys_rst), .stab_phase(stab_phase),
        .cnt_clr(cnt_clr));

    rst_cause_log u_log (
        .clk(clk), .rst(rst), .evt(evt_all), .active(sys_rst), .status(status));

    assign cause_status = status;
    assign reset_vec    = vector_for(monitor_mode);

    // R10
    vector_sel_chk: assert property (@(posedge clk) disable iff (rst)
        monitor_mode |-> (reset_vec[15:8] == 8'hFE && reset_vec[0] == 1'b0));
    // R11
    ext_no_drive_chk: assert property (@(posedge clk) disable iff (rst)
        (pin_qual && !is_long_cause(evt_all) && !is_short_cause(evt_all) && !sys_rst)
        |=> (sys_rst && !rst_pin_drive && !cnt_clr));

endmodule

// File: tb/rst_sequencer_test.sv
module rst_sequencer_test;
    localparam int CLK_PERIOD = 10;
    localparam int STAB = 4096;

    typedef struct packed {
        logic [4:0]  evt;     // [0]por [1]lvd [2]wdog [3]bad_op [4]bad_addr
        logic        mon;
        logic [5:0]  exp_st;
        logic [15:0] exp_vec;
        logic        is_long;
    } vec_t;

    localparam vec_t TBL [6] = '{
        '{5'b00100, 1'b0, 6'b000100, 16'hFFFE, 1'b0},
        '{5'b01000, 1'b1, 6'b001000, 16'hFEFE, 1'b0},
        '{5'b10000, 1'b0, 6'b010000, 16'hFFFE, 1'b0},
        '{5'b01100, 1'b1, 6'b001100, 16'hFEFE, 1'b0},
        '{5'b00010, 1'b0, 6'b000010, 16'hFFFE, 1'b1},
        '{5'b00001, 1'b0, 6'b000001, 16'hFFFE, 1'b1}
    };

    logic clk = 0, rst = 1, ext_low = 0;
    logic por = 0, lvd = 0, wdog = 0, bop = 0, badr = 0, mon = 0;
    logic drive, srst, clr;
    logic [15:0] vec;
    logic [5:0]  status;
    logic        pin_n;
    int errors = 0, checks = 0, clr_seen = 0, cyc = 0;

    assign pin_n = ~(ext_low | drive);

    always #(CLK_PERIOD/2) clk = ~clk;

    rst_sequencer uut (
        .clk(clk), .rst(rst), .rst_pin_n_in(pin_n), .por_evt(por), .lvd_evt(lvd),
        .wdog_evt(wdog), .bad_op_evt(bop), .bad_addr_evt(badr), .monitor_mode(mon),
        .rst_pin_drive(drive), .sys_rst(srst), .cnt_clr(clr), .reset_vec(vec),
        .cause_status(status));

    always @(negedge clk) if (!rst && clr) clr_seen++;

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            errors++; checks++;
            $display("FAIL watchdog: act=%0d exp=<150000 cycles", cyc);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse(input logic [4:0] e);
        {badr, bop, wdog, lvd, por} = e;
        @(negedge clk);
        {badr, bop, wdog, lvd, por} = '0;
    endtask

    initial begin
        int base, c0;
        logic [5:0] prev;
        step(4);
        rst = 0;
        step(1);
        // R1 reset state
        check("R1 sys_rst", srst, 0);
        check("R1 drive", drive, 0);
        check("R1 cnt_clr", clr, 0);
        check("R1 status", status, 0);
        step(3);

        // Table walk: each cause from idle (R2 R3 R5 R6 R7 R10)
        for (int i = 0; i < 6; i++) begin
            mon = TBL[i].mon;
            base = TBL[i].is_long ? STAB : 0;
            c0 = clr_seen;
            pulse(TBL[i].evt);
            check("R6 drive start", drive, 1);
            check("R7 sys_rst start", srst, 1);
            check("R2 clr pulse", clr, 1);
            check("R3 status replace", status, TBL[i].exp_st);
            check("R10 vector", vec, TBL[i].exp_vec);
            step(1);
            check("R2 clr one cycle", clr, 0);
            step(base + 30);
            check("R6 drive last", drive, 1);
            step(1);
            check("R6 drive off", drive, 0);
            check("R7 sys_rst kept", srst, 1);
            step(31);
            check("R7 sys_rst last", srst, 1);
            step(1);
            check("R7 sys_rst off", srst, 0);
            check("R2 clr count", clr_seen - c0, 1);
            step(5);
        end
        mon = 0;

        // R4: a 66-cycle low must not qualify
        prev = status;
        ext_low = 1; step(66); ext_low = 0;
        step(6);
        check("R4 66 no sys_rst", srst, 0);
        check("R4 66 status kept", status, prev);
        step(10);

        // R4 R11 R2: a 67-cycle low qualifies, no counter clear
        c0 = clr_seen;
        ext_low = 1; step(67); ext_low = 0;
        step(5);
        check("R4 67 status", status, 6'b100000);
        check("R11 sys_rst", srst, 1);
        check("R11 no drive", drive, 0);
        step(30);
        check("R11 hold", srst, 1);
        step(2);
        check("R11 release", srst, 0);
        check("R2 no clr on pin", clr_seen - c0, 0);
        step(5);

        // R9 R3: short restart during drive, status ORs
        pulse(5'b00100);
        step(19);
        pulse(5'b01000);
        check("R3 or while active", status, 6'b001100);
        step(31);
        check("R9 restarted drive", drive, 1);
        step(2);
        check("R9 drive end", drive, 0);
        step(40);
        check("R9 idle", srst, 0);

        // R9: short during stabilisation does not shorten it
        pulse(5'b00010);
        step(99);
        pulse(5'b00100);
        check("R3 lvd+wdog", status, 6'b000110);
        step(STAB + 32 - 101);
        check("R9 stab kept", drive, 1);
        step(2);
        check("R9 stab end", drive, 0);
        step(40);

        // R8: power-on during an active sequence clears other bits
        pulse(5'b10000);
        step(9);
        pulse(5'b00001);
        check("R8 por clears", status, 6'b000001);
        check("R5 stab drive", drive, 1);
        step(STAB + 80);
        check("R8 idle after", srst, 0);

        // R5: pin held low from power-on; qualification suspended in stabilisation
        ext_low = 1;
        pulse(5'b00001);
        step(4162);
        check("R5 pin not yet", status[5], 0);
        step(7);
        check("R5 pin later", status[5], 1);
        ext_low = 0;
        step(60);
        check("R11 released", srst, 0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule